// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block sits beside a controller that drives a four-bank SDRAM device and watches the decoded command stream it issues. For every bank it keeps an open flag and the row number latched when the bank was activated, and it reports whether every bank is idle. Each command is checked against the current bank state and two minimum-delay windows: the wait after a mode-register load and the wait after a precharge. A command that breaks a rule raises a one-cycle error pulse with a reason code and leaves the tracked state untouched.

Reads and writes with address bit 10 set schedule an automatic close of their bank a fixed burst length later. Precharge with bit 10 set closes every bank; with bit 10 clear it closes only the addressed bank. The delay lengths and the burst length are parameters.

Top module: `sdram_bank_tracker`

## Requirements
- R1: A synchronous active-high reset clears every open flag, every stored row, every delay counter and the error output; all_idle reads 1 in the cycle after reset.
- R2: Command codes are 0 nop, 1 mode load, 2 activate, 3 read, 4 write, 5 precharge; codes 6 and 7 act as nop. An accepted activate sets the open flag of the bank selected by `bank` and stores all 13 address bits as its row in open_row bits [13*b+12:13*b], visible one cycle after the command.
- R3: An activate to a bank that is already open is flagged with code 4.
- R4: A read or write to an idle bank is flagged with code 6.
- R5: A read or write with address bit 10 set, issued in cycle t, closes its bank so that its open flag reads 0 from cycle t+BURST_LEN+1; a read or write to that bank while the close is pending is flagged with code 7, while bit 10 clear leaves the bank open.
- R6: A precharge with address bit 10 set closes all banks whatever `bank` holds; with bit 10 clear it closes only the selected bank. A precharge of an idle bank is not flagged.
- R7: After a bank is closed by a precharge in cycle t (or automatically, as in R5), an activate to that bank before cycle t+RP_CYC is flagged with code 5.
- R8: A mode load while any bank is open is flagged with code 1.
- R9: A mode load with address bit 12 high (and all banks idle) is flagged with code 2.
- R10: After an accepted mode load in cycle t, any command other than a nop before cycle t+MRD_CYC is flagged with code 3; this check has the highest priority, then codes 1/2 for mode loads, 4 before 5 for activates, 6 before 7 for accesses.
- R11: err and err_code appear one cycle after the offending command, last one cycle, and a flagged command changes no open flag, row, or delay counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Decoded command code |
| bank | input | 2 | Bank address |
| addr | input | 13 | Address bus (row, column, bit 10 selector, mode value) |
| bank_open | output | 4 | One open flag per bank |
| open_row | output | 52 | Stored row of each bank, 13 bits per bank |
| all_idle | output | 1 | High when no bank is open |
| err | output | 1 | One-cycle pulse for an illegal command |
| err_code | output | 3 | Reason for the error, 0 when none |

## Verification
The assertions check on every cycle that a non-nop inside the mode-load window, an activate to an open bank and a mode load with open banks each produce the matching code, that a flagged activate leaves the stored rows stable, and that an all-bank precharge empties every open flag. The timing of the automatic close, the exact edge where the precharge window ends, the ignored bank address of an all-bank precharge, and the silence of a precharge to an idle bank are shown only by the bench scenarios, which compare every output against a behavioural model on each clock.

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int ROW_W     = 13,
  parameter int MRD_CYC   = 2,
  parameter int RP_CYC    = 3,
  parameter int BURST_LEN = 4,
  localparam int NB = 4,
  localparam int MW = $clog2(MRD_CYC + 1),
  localparam int PW = $clog2(RP_CYC + 1),
  localparam int AW = $clog2(BURST_LEN + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            cmd,
  input  logic [1:0]            bank,
  input  logic [ROW_W-1:0]      addr,
  output logic [NB-1:0]         bank_open,
  output logic [NB*ROW_W-1:0]   open_row,
  output logic                  all_idle,
  output logic                  err,
  output logic [2:0]            err_code
);
  localparam logic [2:0] C_MODE = 3'd1, C_ACT = 3'd2, C_RD = 3'd3, C_WR = 3'd4, C_PRE = 3'd5;

  logic [MW-1:0]    mrd_cnt;
  logic [PW-1:0]    rp_cnt [NB];
  logic [AW-1:0]    ap_cnt [NB];
  logic [ROW_W-1:0] row_q  [NB];
  logic [2:0]       code_d;
  logic             is_cmd;

  assign is_cmd   = cmd inside {C_MODE, C_ACT, C_RD, C_WR, C_PRE};
  assign all_idle = ~|bank_open;

  always_comb begin
    code_d = 3'd0;
    if (is_cmd) begin
      if (mrd_cnt != '0) code_d = 3'd3;
      else begin
        case (cmd)
          C_MODE: if (|bank_open) code_d = 3'd1;
                  else if (addr[12]) code_d = 3'd2;
          C_ACT:  if (bank_open[bank]) code_d = 3'd4;
                  else if (rp_cnt[bank] != '0) code_d = 3'd5;
          C_RD, C_WR: if (!bank_open[bank]) code_d = 3'd6;
                  else if (ap_cnt[bank] != '0) code_d = 3'd7;
          default: code_d = 3'd0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mrd_cnt   <= '0;
      bank_open <= '0;
      err       <= 1'b0;
      err_code  <= 3'd0;
      for (int b = 0; b < NB; b++) begin
        rp_cnt[b] <= '0;
        ap_cnt[b] <= '0;
        row_q[b]  <= '0;
      end
    end else begin
      err      <= code_d != 3'd0;
      err_code <= code_d;
      if (mrd_cnt != '0) mrd_cnt <= mrd_cnt - 1'b1;
      for (int b = 0; b < NB; b++) begin
        if (rp_cnt[b] != '0) rp_cnt[b] <= rp_cnt[b] - 1'b1;
        if (ap_cnt[b] != '0) begin
          ap_cnt[b] <= ap_cnt[b] - 1'b1;
          if (ap_cnt[b] == AW'(1)) begin
            bank_open[b] <= 1'b0;
            rp_cnt[b]    <= PW'(RP_CYC - 1);
          end
        end
      end
      if (is_cmd && code_d == 3'd0) begin
        case (cmd)
          C_MODE: mrd_cnt <= MW'(MRD_CYC - 1);
          C_ACT: begin
            bank_open[bank] <= 1'b1;
            row_q[bank]     <= addr;
          end
          C_RD, C_WR: if (addr[10]) ap_cnt[bank] <= AW'(BURST_LEN);
          C_PRE: for (int b = 0; b < NB; b++)
            if (addr[10] || bank == 2'(b)) begin
              bank_open[b] <= 1'b0;
              ap_cnt[b]    <= '0;
              rp_cnt[b]    <= PW'(RP_CYC - 1);
            end
          default: ;
        endcase
      end
    end
  end

  always_comb
    for (int b = 0; b < NB; b++) open_row[b*ROW_W +: ROW_W] = row_q[b];

  // R10
  mrd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (mrd_cnt != '0 && is_cmd) |=> (err && err_code == 3'd3));
  // R3
  act_open_chk: assert property (@(posedge clk) disable iff (rst)
    (mrd_cnt == '0 && cmd == C_ACT && bank_open[bank]) |=> (err && err_code == 3'd4));
  // R8
  mode_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (mrd_cnt == '0 && cmd == C_MODE && |bank_open) |=> (err && err_code == 3'd1));
  // R11
  flag_row_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_ACT && bank_open[bank]) |=> $stable(open_row));
  // R6
  pre_all_chk: assert property (@(posedge clk) disable iff (rst)
    (mrd_cnt == '0 && cmd == C_PRE && addr[10]) |=> bank_open == '0);
endmodule

// File: tb/tb_sdram_bank_tracker.sv
module tb_sdram_bank_tracker;
  localparam int MRD = 2, RP = 3, BL = 4;
  logic clk = 0, rst = 1;
  logic [2:0] cmd = 0;
  logic [1:0] bank = 0;
  logic [12:0] addr = 0;
  logic [3:0] bank_open;
  logic [51:0] open_row;
  logic all_idle, err;
  logic [2:0] err_code;
  int checks = 0, errors = 0, cyc = 0;

  sdram_bank_tracker #(.MRD_CYC(MRD), .RP_CYC(RP), .BURST_LEN(BL)) dut (
    .clk, .rst, .cmd, .bank, .addr, .bank_open, .open_row, .all_idle, .err, .err_code);

  always #2 clk = ~clk;

  // behavioural model: absolute cycle stamps instead of counters
  int  m_open[4], m_row[4], m_rp_until[4], m_close_at[4];
  int  m_mrd_until, m_err, m_code, now;

  task automatic model_reset();
    for (int b = 0; b < 4; b++) begin
      m_open[b] = 0; m_row[b] = 0; m_rp_until[b] = -1; m_close_at[b] = -1;
    end
    m_mrd_until = -1; m_err = 0; m_code = 0;
  endtask

  task automatic model_step(input int c, input int b, input int a);
    int code = 0;
    for (int k = 0; k < 4; k++)
      if (m_close_at[k] == now) begin
        m_open[k] = 0; m_close_at[k] = -1; m_rp_until[k] = now + RP;
      end
    if (c >= 1 && c <= 5) begin
      if (now < m_mrd_until) code = 3;
      else if (c == 1) begin
        if (m_open[0] | m_open[1] | m_open[2] | m_open[3]) code = 1;
        else if (a[12]) code = 2;
      end else if (c == 2) begin
        if (m_open[b]) code = 4; else if (now < m_rp_until[b]) code = 5;
      end else if (c == 3 || c == 4) begin
        if (!m_open[b]) code = 6; else if (m_close_at[b] >= 0) code = 7;
      end
      if (code == 0) begin
        if (c == 1) m_mrd_until = now + MRD;
        if (c == 2) begin m_open[b] = 1; m_row[b] = a; end
        if ((c == 3 || c == 4) && a[10]) m_close_at[b] = now + BL;
        if (c == 5)
          for (int k = 0; k < 4; k++)
            if (a[10] || k == b) begin
              m_open[k] = 0; m_close_at[k] = -1; m_rp_until[k] = now + RP;
            end
      end
    end
    m_err = (code != 0); m_code = code;
  endtask

  task automatic compare(input string tag);
    logic [3:0] eo;
    logic [51:0] er;
    for (int k = 0; k < 4; k++) begin
      eo[k] = m_open[k][0];
      er[k*13 +: 13] = m_row[k][12:0];
    end
    checks++;
    if (bank_open !== eo || open_row !== er || all_idle !== (eo == 0) ||
        err !== m_err[0] || err_code !== m_code[2:0]) begin
      errors++;
      $display("FAIL %s cycle %0d: open=%b row=%h idle=%b err=%b code=%0d expected open=%b row=%h idle=%b err=%0d code=%0d",
               tag, now, bank_open, open_row, all_idle, err, err_code, eo, er, eo == 0, m_err, m_code);
    end
  endtask

  task automatic step(input int c, input int b, input int a, input string tag);
    cmd = c[2:0]; bank = b[1:0]; addr = a[12:0];
    @(posedge clk);
    model_step(c, b, a);
    now++;
    #1 compare(tag);
  endtask

  task automatic nops(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    now = 0;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    compare("R1 reset state");
    step(2, 0, 13'h1ABC, "R2 activate bank0");
    step(2, 2, 13'h0055, "R2 activate bank2");
    step(6, 1, 13'h1FFF, "R2 code 6 acts as nop");
    step(2, 0, 13'h0777, "R3 activate open bank, R11 row kept");
    step(3, 1, 13'h0010, "R4 read idle bank");
    step(4, 3, 13'h0000, "R4 write idle bank");
    step(4, 0, 13'h0012, "R5 write no auto-precharge keeps open");
    step(3, 2, 13'h0400, "R5 read with auto-precharge");
    step(4, 2, 13'h0001, "R5 access while close pending");
    nops(3, "R5 waiting burst end");
    step(2, 2, 13'h0123, "R7 activate inside precharge window");
    step(2, 2, 13'h0124, "R7 activate still inside window");
    step(2, 2, 13'h0125, "R7 activate after window");
    step(1, 0, 13'h0023, "R8 mode load with open banks");
    step(5, 0, 13'h0000, "R6 single-bank precharge");
    step(2, 0, 13'h0111, "R7 activate right after precharge");
    step(5, 1, 13'h0000, "R6 precharge idle bank not flagged");
    step(2, 1, 13'h0222, "R7 activate idle-precharged bank early");
    step(5, 3, 13'h0400, "R6 precharge all ignores bank address");
    nops(2, "R7 window after precharge all");
    step(1, 0, 13'h1023, "R9 mode load with bit 12 high");
    step(1, 0, 13'h0023, "R10 legal mode load");
    step(2, 1, 13'h0333, "R10 activate inside mode window");
    step(2, 1, 13'h0334, "R10 activate after mode window");
    step(1, 0, 13'h0023, "R8 mode load after window with bank open");
    step(3, 1, 13'h0400, "R5 read auto-precharge bank1");
    nops(5, "R5 bank1 closes");
    step(1, 0, 13'h0031, "R10 mode load all idle");
    step(5, 0, 13'h0400, "R10 precharge inside mode window");
    nops(2, "R11 quiet after flagged command");
    rst = 1;
    @(posedge clk);
    model_reset();
    #1 rst = 0;
    compare("R1 reset after activity");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule